// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block collects level or edge interrupt lines from up to 53 devices and presents them to a few processor contexts. Each context has its own interrupt-pending output. The block holds a per-source priority, a per-context enable set and a per-context priority threshold. A context's output is raised whenever at least one source is pending, enabled for that context and ranked above that context's threshold.

Software in a context takes an interrupt by reading its claim register. The read returns the identifier of the best candidate and, in the same operation, removes that source from the pending set. The source's gateway then holds back any further request from that line until the same identifier is written back to the claim register. This write is the completion.

All configuration and the claim handshake go through a simple 32-bit register bus. A read request is answered on the following cycle. Source identifier 0 is reserved and means "nothing to claim".

Top module: `irq_hub`

## Requirements
- R1: The priority of source s (1..NUM_SRC) is at byte address 4*s and is 3 bits wide. Upper bits read as zero. Address 0, and any address past the last source, reads 0 and ignores writes.
- R2: Pending state is read as 32-bit words from 0x1000 + 4*w. Bit i of word w is source 32*w+i. Bit 0 of word 0 (source 0) always reads 0.
- R3: The enable bits of context c are at 0x2000 + 0x80*c (sources 0..31) and at +0x4 from that (sources 32..63). Bits for source 0 and for sources past NUM_SRC read 0.
- R4: The threshold of context c is at 0x200000 + 0x1000*c and is 3 bits wide. Its claim/complete register is at +0x4 from that.
- R5: A source qualifies for a context when it is pending, is enabled for that context, and has a priority strictly greater than that context's threshold. The context's output is high in exactly the cycles where some source qualifies. A priority of 0 never qualifies.
- R6: A read of a context's claim register returns the ID of the qualifying source with the highest priority, with the lowest ID winning ties, and clears that source's pending bit. It returns 0 when no source qualifies.
- R7: After a claim, the source cannot become pending again, even if its line stays asserted, until its ID is written to a claim register as a completion.
- R8: When a source is enabled in several contexts, only the first claim returns it. A later claim from another context returns a different ID or 0.
- R9: A completion write is ignored if its ID is 0, is out of range, or is not enabled for the writing context.
- R10: Trigger-mode words are at 0x1100 + 4*w, with the same bit layout as R2, where 1 selects edge and 0 selects level. A level source becomes pending while its line is high and it is idle. An edge source becomes pending only on a rising edge seen while it is idle. A completion with the line still high re-raises a level source but not an edge source.
- R11: A read request is answered exactly one cycle later, with rd_valid high and the data on rd_data. Writes take effect at the clock edge that samples them.
- R12: With NUM_SRC = 0, no output is ever raised and every claim read returns 0.
- R13: After reset, all priorities, enables, thresholds and trigger modes are 0, nothing is pending, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_irq | input | max(NUM_SRC,1) | Device interrupt lines; bit s-1 is source s |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data |
| eip | output | NUM_CTX | Per-context interrupt-pending output |

## Verification
The bench builds two instances side by side on the same bus. The first uses the defaults: 53 sources, 2 contexts and 3-bit priorities. This exercises the second pending and enable word, the rule that the first of two contexts to claim wins, and completions from a context that does not own the source. The second instance has zero sources, so the degraded case can be checked on every cycle the first one is driven. Randomized sequences of line changes, claims and completions are run on all-level sources against a bench model. Directed cases cover the ties, the strict threshold, edge mode and out-of-range addresses.

// File: rtl/irq_hub_pkg.sv
// Package: shared address map constants and the access-kind type used by
// the register decoder and the top of the interrupt hub.
package irq_hub_pkg;

    localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] TRIG_BASE  = 32'h0000_1100;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] THR_BASE   = 32'h0020_0000;
    localparam logic [31:0] THR_STRIDE = 32'h0000_1000;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PRIO,
        ACC_PEND,
        ACC_TRIG,
        ACC_EN,
        ACC_THR,
        ACC_CLAIM
    } acc_kind_e;

endpackage

// File: rtl/irq_gate.sv
// Module: irq_gate
// Per-source gateway. Turns a device line into at most one outstanding
// request. A claim moves the request into service; a completion ends
// service. Level mode re-requests while the line is high and idle; edge
// mode requests only on a rising edge seen while idle.
// Assumes take and finish are never high in the same cycle, and that take
// is only raised while pend_o is high.
module irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    input  logic edge_sel,
    input  logic take,
    input  logic finish,
    output logic pend_o
);
    logic line_q;
    logic busy_q;
    logic raise;

    // Request condition for the selected trigger mode.
    always_comb raise = edge_sel ? (line_in & ~line_q) : line_in;

    // Gateway state: previous line sample, pending flag, in-service flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend_o <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            line_q <= line_in;
            if (take) begin
                pend_o <= 1'b0;
                busy_q <= 1'b1;
            end else begin
                if (finish)
                    busy_q <= 1'b0;
                if (!pend_o && (!busy_q || finish) && raise)
                    pend_o <= 1'b1;
            end
        end
    end

    // R6: a claim removes the request and starts service.
    a_r6_claim_moves: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (!pend_o && busy_q));

    // R7: while in service and not completed, no new request appears.
    a_r7_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !finish) |=> !pend_o);

    // R7: a completion ends service.
    a_r7_complete_frees: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !busy_q);

endmodule

// File: rtl/irq_pick.sv
// Module: irq_pick
// Per-context arbiter. Among the qualifying sources it selects the one with
// the highest priority, the lowest ID winning ties. It reports ID 0 when
// nothing qualifies.
// Assumes elig bit 0 is always 0 (source 0 is reserved).
module irq_pick #(
    parameter int SRC_N  = 54,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 6
) (
    input  logic [SRC_N-1:0]        elig,
    input  logic [SRC_N*PRIO_W-1:0] prio_flat,
    output logic [ID_W-1:0]         best,
    output logic                    any
);
    logic [PRIO_W-1:0] top;

    // Scan from the highest ID down so that an equal priority later in the
    // scan (a lower ID) replaces the earlier pick.
    always_comb begin
        best = '0;
        top  = '0;
        for (int s = SRC_N - 1; s >= 1; s--) begin
            if (elig[s] && prio_flat[s*PRIO_W +: PRIO_W] >= top) begin
                top  = prio_flat[s*PRIO_W +: PRIO_W];
                best = ID_W'(s);
            end
        end
    end

    // Output-pending flag: any qualifying source.
    always_comb any = |elig;

endmodule

// File: rtl/irq_decode.sv
// Module: irq_decode
// Register address decoder. It classifies a word-aligned byte address into
// an access kind plus the source ID, context and word index the kind needs.
// Addresses that are unaligned or outside every implemented register
// decode to ACC_NONE.
module irq_decode
    import irq_hub_pkg::*;
#(
    parameter int ADDR_W  = 26,
    parameter int NUM_SRC = 53,
    parameter int NUM_CTX = 2,
    parameter int NWORDS  = 2,
    parameter int ID_W    = 6,
    parameter int CTX_W   = 1,
    parameter int WD_W    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [ID_W-1:0]   id_o,
    output logic [CTX_W-1:0]  ctx_o,
    output logic [WD_W-1:0]   word_o
);
    logic [31:0] a;

    // Zero-extend the bus address to the width of the map constants.
    always_comb a = {{(32-ADDR_W){1'b0}}, addr};

    // Region classification and field extraction.
    always_comb begin
        kind   = ACC_NONE;
        id_o   = '0;
        ctx_o  = '0;
        word_o = '0;
        if (a[1:0] != 2'b00) begin
            kind = ACC_NONE;
        end else if (a < PEND_BASE) begin
            if ((a >> 2) >= 32'd1 && (a >> 2) <= 32'(NUM_SRC)) begin
                kind = ACC_PRIO;
                id_o = ID_W'((a - PRIO_BASE) >> 2);
            end
        end else if (a < PEND_BASE + 32'(4 * NWORDS)) begin
            kind   = ACC_PEND;
            word_o = WD_W'((a - PEND_BASE) >> 2);
        end else if (a >= TRIG_BASE && a < TRIG_BASE + 32'(4 * NWORDS)) begin
            kind   = ACC_TRIG;
            word_o = WD_W'((a - TRIG_BASE) >> 2);
        end else if (a >= EN_BASE && a < EN_BASE + EN_STRIDE * 32'(NUM_CTX)) begin
            if (((a - EN_BASE) & 32'h7C) < 32'(4 * NWORDS)) begin
                kind   = ACC_EN;
                ctx_o  = CTX_W'((a - EN_BASE) >> 7);
                word_o = WD_W'(((a - EN_BASE) & 32'h7C) >> 2);
            end
        end else if (a >= THR_BASE && a < THR_BASE + THR_STRIDE * 32'(NUM_CTX)) begin
            ctx_o = CTX_W'((a - THR_BASE) >> 12);
            if (((a - THR_BASE) & 32'hFFF) == 32'h0)
                kind = ACC_THR;
            else if (((a - THR_BASE) & 32'hFFF) == 32'h4)
                kind = ACC_CLAIM;
        end
    end

endmodule

// File: rtl/irq_hub.sv
// Module: irq_hub
// Interrupt hub top. It holds the priority, enable, threshold and
// trigger-mode storage, one gateway per source, and one arbiter per
// context. It serves the register bus and carries out the claim and
// completion handshake.
// Assumes at most one bus access per cycle, so two contexts never claim in
// the same cycle. Read data is registered; a claim clears the pending bit
// at the same edge that captures the returned ID.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 53,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3,
    parameter int ADDR_W  = 26,
    localparam int SRC_N  = NUM_SRC + 1,
    localparam int IN_W   = (NUM_SRC > 0) ? NUM_SRC : 1,
    localparam int NWORDS = (SRC_N + 31) / 32,
    localparam int ID_W   = (SRC_N > 1) ? $clog2(SRC_N) : 1,
    localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
    localparam int WD_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IN_W-1:0]    src_irq,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    output logic [NUM_CTX-1:0] eip
);
    logic [PRIO_W-1:0]  prio_q [SRC_N];
    logic [NUM_CTX-1:0] en_q   [SRC_N];
    logic               trig_q [SRC_N];
    logic [PRIO_W-1:0]  thr_q  [NUM_CTX];
    logic [SRC_N-1:0]   pend;
    logic [SRC_N-1:0]   elig   [NUM_CTX];
    logic [SRC_N*PRIO_W-1:0] prio_flat;
    logic [ID_W-1:0]    best_id [NUM_CTX];

    acc_kind_e          kind;
    logic [ID_W-1:0]    id_i;
    logic [CTX_W-1:0]   ctx_i;
    logic [WD_W-1:0]    word_i;
    logic               rd_req, wr_req, claim_hit, done_hit;
    logic [ID_W-1:0]    sel_id;

    logic [31:0]        pend_w [NWORDS];
    logic [31:0]        trig_w [NWORDS];
    logic [31:0]        en_w   [NWORDS];
    logic [31:0]        rd_mux;

    irq_decode #(
        .ADDR_W (ADDR_W),
        .NUM_SRC(NUM_SRC),
        .NUM_CTX(NUM_CTX),
        .NWORDS (NWORDS),
        .ID_W   (ID_W),
        .CTX_W  (CTX_W),
        .WD_W   (WD_W)
    ) u_decode (
        .addr  (bus_addr),
        .kind  (kind),
        .id_o  (id_i),
        .ctx_o (ctx_i),
        .word_o(word_i)
    );

    // Bus request qualifiers and the claim and completion strobes.
    always_comb begin
        rd_req    = bus_valid && !bus_write;
        wr_req    = bus_valid && bus_write;
        claim_hit = rd_req && (kind == ACC_CLAIM);
        done_hit  = wr_req && (kind == ACC_CLAIM);
        sel_id    = best_id[ctx_i];
    end

    // Per-source storage, gateway and handshake strobes.
    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        if (s == 0) begin : g_rsv
            assign pend[0] = 1'b0;
            // Source 0 is reserved: its storage stays at zero.
            always_ff @(posedge clk) begin
                prio_q[0] <= '0;
                en_q[0]   <= '0;
                trig_q[0] <= 1'b0;
            end
        end else begin : g_live
            logic take_s;
            logic done_s;

            // Claim strobe for this source, and a completion that is
            // accepted only if the writing context has this source enabled.
            always_comb begin
                take_s = claim_hit && (int'(sel_id) == s);
                done_s = done_hit && en_q[s][ctx_i] && (bus_wdata == 32'(s));
            end

            // Priority, trigger-mode and enable bits of this source.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    prio_q[s] <= '0;
                    trig_q[s] <= 1'b0;
                    en_q[s]   <= '0;
                end else if (wr_req) begin
                    if (kind == ACC_PRIO && int'(id_i) == s)
                        prio_q[s] <= bus_wdata[PRIO_W-1:0];
                    if (kind == ACC_TRIG && int'(word_i) == s / 32)
                        trig_q[s] <= bus_wdata[s % 32];
                    if (kind == ACC_EN && int'(word_i) == s / 32)
                        en_q[s][ctx_i] <= bus_wdata[s % 32];
                end
            end

            irq_gate u_gate (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_in (src_irq[s-1]),
                .edge_sel(trig_q[s]),
                .take    (take_s),
                .finish  (done_s),
                .pend_o  (pend[s])
            );
        end
    end

    // Flattened priority vector for the arbiters.
    always_comb begin
        for (int s = 0; s < SRC_N; s++)
            prio_flat[s*PRIO_W +: PRIO_W] = prio_q[s];
    end

    // Qualification: pending, enabled, and strictly above the threshold.
    always_comb begin
        for (int c = 0; c < NUM_CTX; c++)
            for (int s = 0; s < SRC_N; s++)
                elig[c][s] = pend[s] && en_q[s][c] && (prio_q[s] > thr_q[c]);
    end

    // Per-context threshold registers and arbiters.
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
        // Threshold write for this context.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr_q[c] <= '0;
            else if (wr_req && kind == ACC_THR && int'(ctx_i) == c)
                thr_q[c] <= bus_wdata[PRIO_W-1:0];
        end

        irq_pick #(
            .SRC_N (SRC_N),
            .PRIO_W(PRIO_W),
            .ID_W  (ID_W)
        ) u_pick (
            .elig     (elig[c]),
            .prio_flat(prio_flat),
            .best     (best_id[c]),
            .any      (eip[c])
        );

        // R5: a raised output always comes with a qualifying pick.
        a_r5_pick_qualifies: assert property (@(posedge clk) disable iff (!rst_n)
            eip[c] |-> (best_id[c] != '0 && elig[c][best_id[c]]));

        // R6: a claim by this context while nothing qualifies returns 0.
        a_r6_idle_claim_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_hit && int'(ctx_i) == c && !eip[c]) |=> (rd_data == 32'h0));
    end

    // Word views of the pending, trigger and selected-context enable bits.
    always_comb begin
        for (int w = 0; w < NWORDS; w++) begin
            pend_w[w] = '0;
            trig_w[w] = '0;
            en_w[w]   = '0;
        end
        for (int s = 0; s < SRC_N; s++) begin
            pend_w[s / 32][s % 32] = pend[s];
            trig_w[s / 32][s % 32] = trig_q[s];
            en_w[s / 32][s % 32]   = en_q[s][ctx_i];
        end
    end

    // Read data selection by access kind.
    always_comb begin
        case (kind)
            ACC_PRIO:  rd_mux = 32'(prio_q[id_i]);
            ACC_PEND:  rd_mux = pend_w[word_i];
            ACC_TRIG:  rd_mux = trig_w[word_i];
            ACC_EN:    rd_mux = en_w[word_i];
            ACC_THR:   rd_mux = 32'(thr_q[ctx_i]);
            ACC_CLAIM: rd_mux = 32'(sel_id);
            default:   rd_mux = 32'h0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req)
                rd_data <= rd_mux;
        end
    end

    // R11: every read request gets a response on the next cycle.
    a_r11_read_answered: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    // R11: no response without a request.
    a_r11_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

endmodule

// File: tb/irq_hub_bench.sv
// Bench for irq_hub: directed corner cases followed by a seeded random run
// checked against a bench-side model of the gateways and arbiters.
module irq_hub_bench;
    localparam int NS = 53;
    localparam int NC = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [25:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        rd_valid, e_rd_valid;
    logic [31:0] rd_data, e_rd_data;
    logic [NC-1:0] eip, e_eip;
    logic [0:0]  e_src = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // Bench model state.
    int mprio [NS+1];
    bit men   [NC][NS+1];
    int mthr  [NC];
    bit mtrig [NS+1];
    bit mpend [NS+1];
    bit mbusy [NS+1];
    bit msrc  [NS+1];

    always #2 clk = ~clk;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .src_irq(src),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .eip(eip)
    );

    irq_hub #(.NUM_SRC(0)) u_irq_hub_empty (
        .clk(clk), .rst_n(rst_n), .src_irq(e_src),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .rd_valid(e_rd_valid), .rd_data(e_rd_data), .eip(e_eip)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] a_prio(int s);   return 32'(4 * s); endfunction
    function automatic logic [31:0] a_pend(int w);   return 32'h1000 + 32'(4 * w); endfunction
    function automatic logic [31:0] a_trig(int w);   return 32'h1100 + 32'(4 * w); endfunction
    function automatic logic [31:0] a_en(int c, int w); return 32'h2000 + 32'(128 * c) + 32'(4 * w); endfunction
    function automatic logic [31:0] a_thr(int c);    return 32'h200000 + 32'(4096 * c); endfunction
    function automatic logic [31:0] a_claim(int c);  return a_thr(c) + 32'h4; endfunction

    function automatic int model_pick(int c);
        int best = 0;
        int top = 0;
        for (int s = 1; s <= NS; s++)
            if (mpend[s] && men[c][s] && mprio[s] > mthr[c] && mprio[s] > top) begin
                top = mprio[s];
                best = s;
            end
        return best;
    endfunction

    function automatic logic [31:0] model_word(int w, int kind, int c);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++) begin
            int s = 32 * w + i;
            if (s >= 1 && s <= NS)
                r[i] = (kind == 0) ? mpend[s] : (kind == 1) ? mtrig[s] : men[c][s];
        end
        return r;
    endfunction

    task automatic model_clear();
        for (int s = 0; s <= NS; s++) begin
            mprio[s] = 0; mtrig[s] = 0; mpend[s] = 0; mbusy[s] = 0; msrc[s] = 0;
            for (int c = 0; c < NC; c++) men[c][s] = 0;
        end
        for (int c = 0; c < NC; c++) mthr[c] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        src = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a[25:0]; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d, output logic [31:0] de);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a[25:0];
        @(negedge clk);
        bus_valid = 1'b0;
        chk("R11 read valid", 32'(rd_valid), 32'h1);
        d = rd_data;
        de = e_rd_data;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] d, de;
        rd(a, d, de);
        chk(req, d, exp);
    endtask

    task automatic set_prio(int s, logic [31:0] v);
        wr(a_prio(s), v);
        if (s >= 1 && s <= NS) mprio[s] = int'(v & 32'h7);
    endtask

    task automatic set_thr(int c, logic [31:0] v);
        wr(a_thr(c), v);
        mthr[c] = int'(v & 32'h7);
    endtask

    task automatic set_en(int c, int w, logic [31:0] v);
        wr(a_en(c, w), v);
        for (int i = 0; i < 32; i++) begin
            int s = 32 * w + i;
            if (s >= 1 && s <= NS) men[c][s] = v[i];
        end
    endtask

    task automatic set_trig(int w, logic [31:0] v);
        wr(a_trig(w), v);
        for (int i = 0; i < 32; i++) begin
            int s = 32 * w + i;
            if (s >= 1 && s <= NS) mtrig[s] = v[i];
        end
    endtask

    task automatic set_src(int s, bit v);
        bit old = msrc[s];
        @(negedge clk);
        src[s-1] = v;
        msrc[s] = v;
        if (!mpend[s] && !mbusy[s] && v && (!mtrig[s] || !old))
            mpend[s] = 1;
        @(negedge clk);
    endtask

    task automatic settle_level();
        for (int s = 1; s <= NS; s++)
            if (!mtrig[s] && msrc[s] && !mpend[s] && !mbusy[s]) mpend[s] = 1;
    endtask

    task automatic do_claim(int c, string req);
        logic [31:0] d, de;
        int exp = model_pick(c);
        rd(a_claim(c), d, de);
        chk(req, d, 32'(exp));
        chk("R12 empty claim", de, 32'h0);
        if (exp != 0) begin
            mpend[exp] = 0;
            mbusy[exp] = 1;
        end
    endtask

    task automatic do_complete(int c, int id);
        wr(a_claim(c), 32'(id));
        if (id >= 1 && id <= NS && men[c][id]) mbusy[id] = 0;
        @(negedge clk);
        settle_level();
    endtask

    task automatic chk_eip(string req);
        for (int c = 0; c < NC; c++)
            chk(req, 32'(eip[c]), 32'(model_pick(c) != 0));
        chk("R12 empty outputs", 32'(e_eip), 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        do_reset();

        // R13: reset state.
        @(negedge clk);
        chk("R13 outputs low", 32'(eip), 32'h0);
        rd_chk("R13 priority zero", a_prio(1), 32'h0);
        rd_chk("R13 threshold zero", a_thr(1), 32'h0);
        rd_chk("R13 pending zero", a_pend(0), 32'h0);
        rd_chk("R13 enable zero", a_en(0, 1), 32'h0);
        do_claim(0, "R13 claim empty");

        // R1: priority map, width and reserved addresses.
        set_prio(5, 32'hFFFF_FFFF);
        rd_chk("R1 priority masked", a_prio(5), 32'h7);
        set_prio(53, 32'h3);
        rd_chk("R1 last source", a_prio(53), 32'h3);
        wr(a_prio(0), 32'h5);
        rd_chk("R1 source 0 reserved", a_prio(0), 32'h0);
        wr(a_prio(54), 32'h5);
        rd_chk("R1 past last source", a_prio(54), 32'h0);

        // R3: enable words per context, padding bits read zero.
        set_en(1, 1, 32'hFFFF_FFFF);
        rd_chk("R3 upper word", a_en(1, 1), 32'h003F_FFFF);
        rd_chk("R3 other context untouched", a_en(0, 1), 32'h0);
        set_en(1, 0, 32'hFFFF_FFFF);
        rd_chk("R3 source 0 bit", a_en(1, 0), 32'hFFFF_FFFE);
        set_en(1, 0, 32'h0);
        set_en(1, 1, 32'h0);

        // R4: threshold width and per-context placement.
        set_thr(1, 32'hFF);
        rd_chk("R4 threshold masked", a_thr(1), 32'h7);
        rd_chk("R4 other threshold", a_thr(0), 32'h0);
        set_thr(1, 32'h0);

        // R2 / R5 / R6: three sources, tie at the top priority.
        set_prio(3, 2); set_prio(7, 5); set_prio(40, 5);
        set_en(0, 0, (32'h1 << 3) | (32'h1 << 7));
        set_en(0, 1, 32'h1 << 8);
        set_src(3, 1); set_src(7, 1); set_src(40, 1);
        rd_chk("R2 pending word 0", a_pend(0), (32'h1 << 3) | (32'h1 << 7));
        rd_chk("R2 pending word 1", a_pend(1), 32'h1 << 8);
        chk("R5 output raised", 32'(eip[0]), 32'h1);
        chk("R5 other context idle", 32'(eip[1]), 32'h0);
        set_thr(0, 5);
        @(negedge clk);
        chk("R5 strict threshold", 32'(eip[0]), 32'h0);
        do_claim(0, "R6 nothing above threshold");
        set_thr(0, 4);
        @(negedge clk);
        chk("R5 above threshold", 32'(eip[0]), 32'h1);
        do_claim(0, "R6 tie lowest id");
        chk("R6 tie winner", 32'(mbusy[7]), 32'h1);
        do_claim(0, "R6 second pick");
        rd_chk("R7 no re-pend in service", a_pend(0), 32'h1 << 3);
        @(negedge clk);
        chk("R5 low priority below threshold", 32'(eip[0]), 32'h0);
        set_thr(0, 0);
        do_claim(0, "R6 lowest priority");
        do_claim(0, "R6 empty returns zero");
        chk_eip("R5 all claimed");

        // R9: completions that must be ignored.
        do_complete(1, 7);
        rd_chk("R9 not enabled in context", a_pend(0), 32'h0);
        do_complete(0, 60);
        do_complete(0, 0);
        rd_chk("R9 out of range id", a_pend(0), 32'h0);
        do_complete(0, 7);
        rd_chk("R7 completion re-raises level", a_pend(0), 32'h1 << 7);
        chk_eip("R7 output after completion");

        // R8: shared source, first claim wins.
        set_en(1, 0, 32'h1 << 7);
        @(negedge clk);
        chk("R8 both contexts raised", 32'(eip), 32'h3);
        do_claim(1, "R8 first claimer");
        do_claim(0, "R8 later claimer");
        chk_eip("R8 outputs after claim");
        do_complete(1, 7);

        // R10: edge mode on source 20.
        set_trig(0, 32'h1 << 20);
        rd_chk("R10 trigger readback", a_trig(0), 32'h1 << 20);
        set_prio(20, 6);
        set_en(0, 0, (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20));
        set_src(20, 1);
        rd_chk("R10 edge pends", a_pend(0), model_word(0, 0, 0));
        do_claim(0, "R10 edge source claimed");
        do_complete(0, 20);
        rd_chk("R10 no re-pend without edge", a_pend(0), model_word(0, 0, 0));
        chk("R10 edge idle", 32'(mpend[20]), 32'h0);
        set_src(20, 0);
        set_src(20, 1);
        rd_chk("R10 new edge pends", a_pend(0), model_word(0, 0, 0));
        chk_eip("R10 outputs");

        // Random phase: all level sources, model-checked.
        do_reset();
        for (int s = 1; s <= NS; s++) set_prio(s, $urandom % 8);
        for (int c = 0; c < NC; c++) begin
            set_en(c, 0, $urandom);
            set_en(c, 1, $urandom);
            set_thr(c, $urandom % 4);
        end
        for (int it = 0; it < 500; it++) begin
            int op = int'($urandom % 5);
            int c = int'($urandom % NC);
            if (op <= 1) begin
                int s = 1 + int'($urandom % NS);
                set_src(s, !msrc[s]);
            end else if (op <= 3) begin
                do_claim(c, "R6 random claim");
            end else begin
                int id = ($urandom % 8 == 0) ? 60 : 1 + int'($urandom % NS);
                do_complete(c, id);
            end
            chk_eip("R5 random outputs");
            if (it % 50 == 0) begin
                rd_chk("R2 random pending 0", a_pend(0), model_word(0, 0, 0));
                rd_chk("R2 random pending 1", a_pend(1), model_word(1, 0, 0));
            end
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule